// File: doc/BRIEF.md
# Instruction Skip and Table-Read Carry Controller

This block sits beside the decoder of a small 4-bit processor and decides, for every fetched instruction, whether the instruction really executes and how many machine cycles it occupies. Decoding is abstracted away: the decoder presents a one-hot operation vector together with an issue strobe. A conditional-skip instruction whose test is true sets a pending-skip flag. The next instruction is then fetched normally and still consumes its fetch slot, because the program counter steps by one as usual. Its effects are suppressed, and the flag is used up.

A squashed instruction normally keeps its own cycle count, so program timing does not depend on whether a skip was taken. The exception is a squashed table read, return or return-with-skip, which collapses to a single cycle. A second flag, which can only be set, decides whether bit 8 of a 9-bit ROM word is copied into the carry flag during the second cycle of a table read. Only reset or a wake-up from RAM back-up mode clears that flag.

The control core is a two-state machine. In `ST_READY` it accepts an issue. It stays in `ST_READY` for a one-cycle instruction, or moves to `ST_HOLD` for a two-cycle one (transition "go_hold"). `ST_HOLD` always returns to `ST_READY` on the next edge (transition "release"). Reset and wake-up both force `ST_READY` (transition "restart").

Top module: `sk_ctrl`

## Requirements
- R1: A squashed instruction drives `ins_valid_o` low and keeps `exec_en_o` and `cy_we_o` low in every one of its cycles. It still pulses `pc_inc_o` once, exactly as an executed instruction does.
- R2: `op_i` is one-hot with bit 0 = conditional skip, 1 = table read, 2 = return, 3 = return-with-skip, 4 = top-bit enable set, 5 = generic two-cycle, 6 = generic one-cycle. An executed instruction reports `ins_cycles_o` = 2 for bits 1, 2, 3 and 5, and 1 for the others.
- R3: A squashed generic instruction (bits 0, 4, 5, 6) reports the same cycle count it would report when executed.
- R4: A squashed table read, return or return-with-skip reports `ins_cycles_o` = 1 and does not enter `ST_HOLD`.
- R5: An executed conditional skip with `cond_i` = 1 sets `skip_pending_o`, and so does an executed return-with-skip. A skip with `cond_i` = 0 leaves it clear.
- R6: `skip_pending_o` squashes exactly one instruction and is clear afterwards. A squashed skip or return-with-skip never sets it.
- R7: `top_en_o` is 0 after reset and after a `wake_i` pulse, and `wake_i` also clears `skip_pending_o`.
- R8: An executed enable-set instruction sets `top_en_o` to 1. No instruction clears it again, and a squashed enable-set leaves it unchanged.
- R9: In the second cycle of an executed table read with `top_en_o` = 1, `cy_we_o` = 1 and `cy_d_o` equals `rom_b8_i`. With `top_en_o` = 0, `cy_we_o` stays 0.
- R10: `ready_o` is low exactly during the second cycle of a two-cycle instruction. An issue presented while `ready_o` is low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wake_i | input | 1 | Return from RAM back-up mode; clears both flags |
| issue_i | input | 1 | A fetched instruction is presented this cycle |
| op_i | input | 7 | One-hot decoded operation (encoding in R2) |
| cond_i | input | 1 | Condition result of a conditional-skip instruction |
| rom_b8_i | input | 1 | Bit 8 of the ROM word read by a table read |
| ready_o | output | 1 | Controller can accept an issue |
| pc_inc_o | output | 1 | Program counter steps by one this cycle |
| ins_valid_o | output | 1 | Issued instruction executes (not squashed) |
| ins_cycles_o | output | 2 | Cycles the issued instruction occupies (1 or 2) |
| exec_en_o | output | 1 | Register and stack write enables allowed this cycle |
| cy_we_o | output | 1 | Write carry from ROM bit 8 |
| cy_d_o | output | 1 | Carry value to write |
| skip_pending_o | output | 1 | Next instruction will be squashed |
| top_en_o | output | 1 | ROM bit 8 is routed to carry on table reads |

## Verification
The case that matters is a table read that is itself the squashed target. In that case the pending skip and the enabled bit-8 carry path both refer to the same instruction. The bench sets the enable flag, takes a skip, then issues a table read with ROM bit 8 high. It expects a one-cycle occupancy, no carry write and no `ST_HOLD` cycle. A similar collision arises with a squashed enable-set followed by a table read, where the carry write must stay off.

// File: rtl/sk_pkg.sv
package sk_pkg;

    localparam int NUM_OPS = 7;
    localparam int CYC_W   = 2;

    localparam int OP_SKIP  = 0;
    localparam int OP_TBL   = 1;
    localparam int OP_RET   = 2;
    localparam int OP_RETS  = 3;
    localparam int OP_TOPEN = 4;
    localparam int OP_LONG  = 5;
    localparam int OP_PLAIN = 6;

    // operations that occupy two cycles when executed
    localparam logic [NUM_OPS-1:0] LONG_MASK =
        (NUM_OPS'(1) << OP_TBL) | (NUM_OPS'(1) << OP_RET) |
        (NUM_OPS'(1) << OP_RETS) | (NUM_OPS'(1) << OP_LONG);

    // operations that collapse to one cycle when squashed
    localparam logic [NUM_OPS-1:0] SHRINK_MASK =
        (NUM_OPS'(1) << OP_TBL) | (NUM_OPS'(1) << OP_RET) |
        (NUM_OPS'(1) << OP_RETS);

    localparam logic [CYC_W-1:0] CYC_ONE = CYC_W'(1);
    localparam logic [CYC_W-1:0] CYC_TWO = CYC_W'(2);

    typedef enum logic {
        ST_READY = 1'b0,
        ST_HOLD  = 1'b1
    } sk_state_e;

endpackage

// File: rtl/sk_cycle_calc.sv
module sk_cycle_calc
    import sk_pkg::*;
(
    input  logic [NUM_OPS-1:0] op,
    input  logic               squash,
    output logic [CYC_W-1:0]   cycles
);

    logic [NUM_OPS-1:0] is_long;
    logic [NUM_OPS-1:0] is_shrink;

    for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
        assign is_long[g]   = op[g] & LONG_MASK[g];
        assign is_shrink[g] = op[g] & SHRINK_MASK[g];
    end

    always_comb begin
        if (squash && (|is_shrink)) begin
            cycles = CYC_ONE;
        end else if (|is_long) begin
            cycles = CYC_TWO;
        end else begin
            cycles = CYC_ONE;
        end
    end

endmodule

// File: rtl/sk_skip_flag.sv
module sk_skip_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic wake,
    input  logic accept,
    input  logic set_req,
    output logic pending
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pending <= 1'b0;
        end else if (wake) begin
            pending <= 1'b0;
        end else if (accept) begin
            // a pending skip is consumed by the accepted instruction;
            // only an executed instruction can arm a new one
            pending <= pending ? 1'b0 : set_req;
        end
    end

endmodule

// File: rtl/sk_topbit_en.sv
module sk_topbit_en (
    input  logic clk,
    input  logic rst_n,
    input  logic wake,
    input  logic set_req,
    output logic enable
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enable <= 1'b0;
        end else if (wake) begin
            enable <= 1'b0;
        end else if (set_req) begin
            enable <= 1'b1;
        end
    end

endmodule

// File: rtl/sk_ctrl.sv
module sk_ctrl
    import sk_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wake_i,
    input  logic               issue_i,
    input  logic [NUM_OPS-1:0] op_i,
    input  logic               cond_i,
    input  logic               rom_b8_i,
    output logic               ready_o,
    output logic               pc_inc_o,
    output logic               ins_valid_o,
    output logic [CYC_W-1:0]   ins_cycles_o,
    output logic               exec_en_o,
    output logic               cy_we_o,
    output logic               cy_d_o,
    output logic               skip_pending_o,
    output logic               top_en_o
);

    sk_state_e state_q, state_d;
    logic held_valid_q, held_tbl_q;
    logic accept, squash, arm_skip, set_top;
    logic [CYC_W-1:0] cyc;

    assign accept   = issue_i && (state_q == ST_READY);
    assign squash   = skip_pending_o;
    assign arm_skip = (op_i[OP_SKIP] && cond_i) || op_i[OP_RETS];
    assign set_top  = accept && !squash && op_i[OP_TOPEN];

    sk_cycle_calc u_cyc (
        .op     (op_i),
        .squash (squash),
        .cycles (cyc)
    );

    sk_skip_flag u_skip (
        .clk     (clk),
        .rst_n   (rst_n),
        .wake    (wake_i),
        .accept  (accept),
        .set_req (arm_skip),
        .pending (skip_pending_o)
    );

    sk_topbit_en u_top (
        .clk     (clk),
        .rst_n   (rst_n),
        .wake    (wake_i),
        .set_req (set_top),
        .enable  (top_en_o)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_READY: if (accept && cyc == CYC_TWO) state_d = ST_HOLD;
            ST_HOLD:  state_d = ST_READY;
            default:  state_d = ST_READY;
        endcase
        if (wake_i) state_d = ST_READY;
    end

    // state register and per-instruction context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q      <= ST_READY;
            held_valid_q <= 1'b0;
            held_tbl_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                held_valid_q <= !squash;
                held_tbl_q   <= op_i[OP_TBL];
            end
        end
    end

    // outputs
    always_comb begin
        ready_o      = 1'b0;
        pc_inc_o     = 1'b0;
        ins_valid_o  = 1'b0;
        ins_cycles_o = '0;
        exec_en_o    = 1'b0;
        cy_we_o      = 1'b0;
        cy_d_o       = 1'b0;
        unique case (state_q)
            ST_READY: begin
                ready_o = 1'b1;
                if (accept) begin
                    pc_inc_o     = 1'b1;
                    ins_valid_o  = !squash;
                    ins_cycles_o = cyc;
                    exec_en_o    = !squash;
                end
            end
            ST_HOLD: begin
                exec_en_o = held_valid_q;
                if (held_valid_q && held_tbl_q && top_en_o) begin
                    cy_we_o = 1'b1;
                    cy_d_o  = rom_b8_i;
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/sk_ctrl_chk.sv
module sk_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wake_i,
    input logic       issue_i,
    input logic       ready_o,
    input logic       pc_inc_o,
    input logic       ins_valid_o,
    input logic [1:0] ins_cycles_o,
    input logic       exec_en_o,
    input logic       cy_we_o,
    input logic       skip_pending_o,
    input logic       top_en_o
);

    // R1
    squash_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && ready_o && skip_pending_o) |-> (!ins_valid_o && !exec_en_o && pc_inc_o));

    // R6
    skip_consumed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && ready_o && skip_pending_o) |=> !skip_pending_o);

    // R8
    top_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (top_en_o && !wake_i) |=> top_en_o);

    // R7
    wake_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_i |=> (!top_en_o && !skip_pending_o));

    // R9
    carry_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cy_we_o |-> (top_en_o && !ready_o && exec_en_o));

    // R10
    hold_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_o |=> ready_o);

    // R2
    cycle_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && ready_o) |-> (ins_cycles_o == 2'd1 || ins_cycles_o == 2'd2));

endmodule

bind sk_ctrl sk_ctrl_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .wake_i         (wake_i),
    .issue_i        (issue_i),
    .ready_o        (ready_o),
    .pc_inc_o       (pc_inc_o),
    .ins_valid_o    (ins_valid_o),
    .ins_cycles_o   (ins_cycles_o),
    .exec_en_o      (exec_en_o),
    .cy_we_o        (cy_we_o),
    .skip_pending_o (skip_pending_o),
    .top_en_o       (top_en_o)
);

// File: tb/tb_sk_ctrl.sv
module tb_sk_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wake_i = 1'b0;
    logic       issue_i = 1'b0;
    logic [6:0] op_i = '0;
    logic       cond_i = 1'b0;
    logic       rom_b8_i = 1'b0;
    logic       ready_o, pc_inc_o, ins_valid_o, exec_en_o, cy_we_o, cy_d_o;
    logic       skip_pending_o, top_en_o;
    logic [1:0] ins_cycles_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    sk_ctrl dut (.*);

    always #4 clk = ~clk;

    typedef struct packed {
        logic [2:0] op;
        logic       cond;
        logic       b8;
        logic       ev;
        logic [1:0] ec;
        logic       ew;
    } vec_t;

    // op: 0 skip,1 table,2 ret,3 ret-skip,4 enable-set,5 long,6 plain
    localparam int NV = 23;
    localparam vec_t VECS [NV] = '{
        '{3'd6, 1'b0, 1'b0, 1'b1, 2'd1, 1'b0}, // R2 plain
        '{3'd1, 1'b0, 1'b1, 1'b1, 2'd2, 1'b0}, // R9 table, enable off
        '{3'd0, 1'b0, 1'b0, 1'b1, 2'd1, 1'b0}, // R5 skip, cond false
        '{3'd6, 1'b0, 1'b0, 1'b1, 2'd1, 1'b0}, // R5 not squashed
        '{3'd0, 1'b1, 1'b0, 1'b1, 2'd1, 1'b0}, // R5 skip taken
        '{3'd5, 1'b0, 1'b0, 1'b0, 2'd2, 1'b0}, // R3 squashed long keeps 2
        '{3'd6, 1'b0, 1'b0, 1'b1, 2'd1, 1'b0}, // R6 flag used up
        '{3'd0, 1'b1, 1'b0, 1'b1, 2'd1, 1'b0},
        '{3'd4, 1'b0, 1'b0, 1'b0, 2'd1, 1'b0}, // R8 squashed enable-set
        '{3'd1, 1'b0, 1'b1, 1'b1, 2'd2, 1'b0}, // R8 still off
        '{3'd4, 1'b0, 1'b0, 1'b1, 2'd1, 1'b0}, // R8 enable-set
        '{3'd1, 1'b0, 1'b1, 1'b1, 2'd2, 1'b1}, // R9 carry 1
        '{3'd1, 1'b0, 1'b0, 1'b1, 2'd2, 1'b1}, // R9 carry 0
        '{3'd0, 1'b1, 1'b0, 1'b1, 2'd1, 1'b0},
        '{3'd1, 1'b0, 1'b1, 1'b0, 2'd1, 1'b0}, // R4 squashed table
        '{3'd3, 1'b0, 1'b0, 1'b1, 2'd2, 1'b0}, // R5 ret-skip arms
        '{3'd2, 1'b0, 1'b0, 1'b0, 2'd1, 1'b0}, // R4 squashed return
        '{3'd0, 1'b1, 1'b0, 1'b1, 2'd1, 1'b0},
        '{3'd3, 1'b0, 1'b0, 1'b0, 2'd1, 1'b0}, // R4 squashed ret-skip
        '{3'd6, 1'b0, 1'b0, 1'b1, 2'd1, 1'b0}, // R6 no re-arm
        '{3'd0, 1'b1, 1'b0, 1'b1, 2'd1, 1'b0},
        '{3'd0, 1'b1, 1'b0, 1'b0, 2'd1, 1'b0}, // R6 squashed skip
        '{3'd6, 1'b0, 1'b0, 1'b1, 2'd1, 1'b0}  // R6 no re-arm
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v);
        @(negedge clk);
        issue_i = 1'b1;
        op_i = 7'(1) << v.op;
        cond_i = v.cond;
        rom_b8_i = v.b8;
        #1;
        chk(ins_valid_o == v.ev, "R1 valid", ins_valid_o, v.ev);
        chk(exec_en_o == v.ev, "R1 exec", exec_en_o, v.ev);
        chk(pc_inc_o == 1'b1, "R1 pc step", pc_inc_o, 1);
        chk(ins_cycles_o == v.ec, "R2 cycles", ins_cycles_o, v.ec);
        @(negedge clk);
        issue_i = 1'b0;
        #1;
        if (v.ec == 2'd2) begin
            chk(ready_o == 1'b0, "R10 hold", ready_o, 0);
            chk(exec_en_o == v.ev, "R1 hold exec", exec_en_o, v.ev);
            chk(cy_we_o == v.ew, "R9 cy_we", cy_we_o, v.ew);
            if (v.ew) chk(cy_d_o == v.b8, "R9 cy_d", cy_d_o, v.b8);
            @(negedge clk);
            #1;
        end else begin
            chk(cy_we_o == 1'b0, "R9 no write", cy_we_o, 0);
        end
        chk(ready_o == 1'b1, "R10 ready", ready_o, 1);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(ready_o == 1'b1, "R10 reset ready", ready_o, 1);
        chk(top_en_o == 1'b0, "R7 reset top_en", top_en_o, 0);
        chk(skip_pending_o == 1'b0, "R7 reset skip", skip_pending_o, 0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R10: issue during hold is ignored
        @(negedge clk);
        issue_i = 1'b1; op_i = 7'b0100000; cond_i = 1'b0;
        @(negedge clk);
        op_i = 7'b0000001; cond_i = 1'b1;
        #1;
        chk(pc_inc_o == 1'b0, "R10 ignored pc", pc_inc_o, 0);
        @(negedge clk);
        issue_i = 1'b0;
        #1;
        chk(skip_pending_o == 1'b0, "R10 ignored skip", skip_pending_o, 0);

        // R7: wake clears both flags
        chk(top_en_o == 1'b1, "R8 top_en held", top_en_o, 1);
        run_vec('{3'd0, 1'b1, 1'b0, 1'b1, 2'd1, 1'b0});
        chk(skip_pending_o == 1'b1, "R5 armed", skip_pending_o, 1);
        @(negedge clk);
        wake_i = 1'b1;
        @(negedge clk);
        wake_i = 1'b0;
        #1;
        chk(top_en_o == 1'b0, "R7 wake top_en", top_en_o, 0);
        chk(skip_pending_o == 1'b0, "R7 wake skip", skip_pending_o, 0);
        run_vec('{3'd1, 1'b0, 1'b1, 1'b1, 2'd2, 1'b0}); // R7 table after wake

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule